// File: doc/BRIEF.md
# Bus Statistics Event Generator

This block watches the slave side of a shared system bus and the responses returned to the active master. Each clock it sorts the bus cycle into event categories and raises one single-cycle pulse per category for a bank of performance counters elsewhere on the chip. The categories are the transfer type, the direction of an active transfer, its size, wait states, and retry or split responses.

A trace filter elsewhere decides whether each bus cycle is of interest and supplies that decision as an input. When the performance-filter control bit is set, a cycle that the filter rejects raises no event at all. When the bit is clear, the decision is ignored. Every event output is registered, so counters see a clean one-cycle pulse one clock after the bus cycle that caused it.

Top module: `busstat_evgen`

## Requirements
- R1: With `hready` high, a `htrans` code of 0 (idle), 1 (busy), 2 (nonsequential) or 3 (sequential) raises exactly the matching one of `ev_idle`, `ev_busy`, `ev_nseq`, `ev_seq`. With `hready` low, none of these four fire.
- R2: `ev_read` fires for an active transfer (`htrans` 2 or 3) with `hready` high and `hwrite` low. `ev_write` fires under the same conditions with `hwrite` high. The two never fire together.
- R3: For an active transfer with `hready` high, bit n of `ev_size` fires when `hsize` equals n, for n from 0 to 5. At most one bit is set.
- R4: `hsize` codes 6 and 7 raise no bit of `ev_size`. Idle or busy cycles raise no size bit.
- R5: `ev_wait` fires whenever `hready` is low and `hresp` is OKAY (code 0), whatever `htrans` carries.
- R6: `ev_retry` fires when `hresp` is RETRY (code 2) with `hready` high, and `ev_split` fires when `hresp` is SPLIT (code 3) with `hready` high. An ERROR response (code 1), or the first cycle of a response with `hready` low, raises neither event. These events do not depend on `htrans`.
- R7: When `filt_en` and `filt_reject` are both high in a cycle, no event fires for that cycle. When `filt_en` is low, `filt_reject` has no effect.
- R8: Every event appears exactly one clock after its qualifying cycle and lasts one clock per qualifying cycle. A synchronous reset clears all event outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| htrans | input | 2 | Transfer type seen by the slaves |
| hready | input | 1 | Transfer-complete / ready seen by the slaves |
| hwrite | input | 1 | Direction of the transfer (1 = write) |
| hsize | input | 3 | Transfer size code |
| hresp | input | 2 | Response code returned to the master |
| filt_en | input | 1 | Performance-filter control bit |
| filt_reject | input | 1 | Trace filter decision for this cycle (1 = rejected) |
| ev_idle | output | 1 | Idle transfer event |
| ev_busy | output | 1 | Busy transfer event |
| ev_nseq | output | 1 | Nonsequential transfer event |
| ev_seq | output | 1 | Sequential transfer event |
| ev_read | output | 1 | Read access event |
| ev_write | output | 1 | Write access event |
| ev_size | output | 6 | One-hot transfer size event |
| ev_wait | output | 1 | Wait-state event |
| ev_retry | output | 1 | Retry response event |
| ev_split | output | 1 | Split response event |

## Verification
A response event and a transfer event can land in the same cycle. When the retry or split response completes with `hready` high, the next master may already be driving a nonsequential address. The bench drives exactly that cycle, with `hresp` set to RETRY or SPLIT, `htrans` nonsequential and a chosen size. It expects the response pulse and the type, direction and size pulses all together one clock later. The same combined cycle is repeated with the filter gate active, where every output must stay low.

// File: rtl/busstat_pkg.sv
package busstat_pkg;

    localparam int SIZE_CODE_W = 3;
    localparam int N_SIZE_EV   = 6;
    localparam int N_TYPE_EV   = 4;

    typedef enum logic [1:0] {
        TR_IDLE = 2'd0,
        TR_BUSY = 2'd1,
        TR_NSEQ = 2'd2,
        TR_SEQ  = 2'd3
    } trans_e;

    typedef enum logic [1:0] {
        RS_OKAY  = 2'd0,
        RS_ERROR = 2'd1,
        RS_RETRY = 2'd2,
        RS_SPLIT = 2'd3
    } resp_e;

    typedef struct packed {
        logic [N_TYPE_EV-1:0] kind;   // one-hot, indexed by trans_e
        logic                 rd;
        logic                 wr;
        logic [N_SIZE_EV-1:0] size;
    } xfer_ev_t;

    typedef struct packed {
        logic wt;
        logic retry;
        logic split;
    } resp_ev_t;

    typedef struct packed {
        xfer_ev_t xfer;
        resp_ev_t resp;
    } bus_ev_t;

    function automatic logic is_active(input trans_e t);
        return (t == TR_NSEQ) || (t == TR_SEQ);
    endfunction

endpackage

// File: rtl/bse_xfer_decode.sv
module bse_xfer_decode
    import busstat_pkg::*;
#(
    parameter int SW = SIZE_CODE_W,
    parameter int NS = N_SIZE_EV
) (
    input  logic [1:0]    htrans,
    input  logic          hready,
    input  logic          hwrite,
    input  logic [SW-1:0] hsize,
    output xfer_ev_t      ev
);
    trans_e tr;
    logic   act;

    assign tr  = trans_e'(htrans);
    assign act = hready && is_active(tr);

    genvar k;
    generate
        for (k = 0; k < N_TYPE_EV; k++) begin : g_kind
            assign ev.kind[k] = hready && (htrans == k[1:0]);
        end
        for (k = 0; k < NS; k++) begin : g_size
            assign ev.size[k] = act && (hsize == k[SW-1:0]);
        end
    endgenerate

    assign ev.rd = act && !hwrite;
    assign ev.wr = act && hwrite;
endmodule

// File: rtl/bse_resp_decode.sv
module bse_resp_decode
    import busstat_pkg::*;
(
    input  logic     hready,
    input  logic [1:0] hresp,
    output resp_ev_t ev
);
    resp_e rs;
    assign rs = resp_e'(hresp);

    always_comb begin
        ev       = '0;
        ev.wt    = !hready && (rs == RS_OKAY);
        ev.retry = hready && (rs == RS_RETRY);
        ev.split = hready && (rs == RS_SPLIT);
    end
endmodule

// File: rtl/bse_gate_reg.sv
module bse_gate_reg
    import busstat_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cut,
    input  bus_ev_t ev_in,
    output bus_ev_t ev_q
);
    always_ff @(posedge clk) begin
        if (rst || cut) ev_q <= '0;
        else            ev_q <= ev_in;
    end
endmodule

// File: rtl/busstat_evgen.sv
module busstat_evgen
    import busstat_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            htrans,
    input  logic                  hready,
    input  logic                  hwrite,
    input  logic [SIZE_CODE_W-1:0] hsize,
    input  logic [1:0]            hresp,
    input  logic                  filt_en,
    input  logic                  filt_reject,
    output logic                  ev_idle,
    output logic                  ev_busy,
    output logic                  ev_nseq,
    output logic                  ev_seq,
    output logic                  ev_read,
    output logic                  ev_write,
    output logic [N_SIZE_EV-1:0]  ev_size,
    output logic                  ev_wait,
    output logic                  ev_retry,
    output logic                  ev_split
);
    xfer_ev_t xf;
    resp_ev_t rp;
    bus_ev_t  comb_ev;
    bus_ev_t  reg_ev;
    logic     cut;

    bse_xfer_decode #(.SW(SIZE_CODE_W), .NS(N_SIZE_EV)) u_xfer (
        .htrans (htrans),
        .hready (hready),
        .hwrite (hwrite),
        .hsize  (hsize),
        .ev     (xf)
    );

    bse_resp_decode u_resp (
        .hready (hready),
        .hresp  (hresp),
        .ev     (rp)
    );

    assign cut          = filt_en && filt_reject;
    assign comb_ev.xfer = xf;
    assign comb_ev.resp = rp;

    bse_gate_reg u_out (
        .clk   (clk),
        .rst   (rst),
        .cut   (cut),
        .ev_in (comb_ev),
        .ev_q  (reg_ev)
    );

    assign ev_idle  = reg_ev.xfer.kind[TR_IDLE];
    assign ev_busy  = reg_ev.xfer.kind[TR_BUSY];
    assign ev_nseq  = reg_ev.xfer.kind[TR_NSEQ];
    assign ev_seq   = reg_ev.xfer.kind[TR_SEQ];
    assign ev_read  = reg_ev.xfer.rd;
    assign ev_write = reg_ev.xfer.wr;
    assign ev_size  = reg_ev.xfer.size;
    assign ev_wait  = reg_ev.resp.wt;
    assign ev_retry = reg_ev.resp.retry;
    assign ev_split = reg_ev.resp.split;
endmodule

// File: rtl/busstat_evgen_chk.sv
module busstat_evgen_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] htrans,
    input logic       hready,
    input logic       hwrite,
    input logic [2:0] hsize,
    input logic [1:0] hresp,
    input logic       filt_en,
    input logic       filt_reject,
    input logic       ev_idle,
    input logic       ev_busy,
    input logic       ev_nseq,
    input logic       ev_seq,
    input logic       ev_read,
    input logic       ev_write,
    input logic [5:0] ev_size,
    input logic       ev_wait,
    input logic       ev_retry,
    input logic       ev_split
);
    logic pass;
    assign pass = !(filt_en && filt_reject);

    // R1: one type event per ready cycle, matching the code
    a_r1_type_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev_idle, ev_busy, ev_nseq, ev_seq}));
    a_r1_nseq: assert property (@(posedge clk) disable iff (rst)
        (pass && hready && htrans == 2'd2) |=> ev_nseq);
    a_r1_no_type_unready: assert property (@(posedge clk) disable iff (rst)
        !hready |=> !(ev_idle || ev_busy || ev_nseq || ev_seq));

    // R2: read and write exclusive
    a_r2_rw_excl: assert property (@(posedge clk) disable iff (rst)
        !(ev_read && ev_write));

    // R3: size vector one-hot
    a_r3_size_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ev_size));

    // R4: large size codes raise nothing
    a_r4_no_big_size: assert property (@(posedge clk) disable iff (rst)
        (hsize[2] && hsize[1]) |=> (ev_size == 6'd0));

    // R5: wait state regardless of htrans
    a_r5_wait: assert property (@(posedge clk) disable iff (rst)
        (pass && !hready && hresp == 2'd0) |=> ev_wait);

    // R6: error response never counts as retry or split
    a_r6_error: assert property (@(posedge clk) disable iff (rst)
        (hresp == 2'd1) |=> !(ev_retry || ev_split || ev_wait));

    // R7: filter gate silences everything
    a_r7_gate: assert property (@(posedge clk) disable iff (rst)
        !pass |=> ({ev_idle, ev_busy, ev_nseq, ev_seq, ev_read, ev_write,
                    ev_size, ev_wait, ev_retry, ev_split} == 15'd0));

    // R8: outputs low in the cycle after reset
    a_r8_reset: assert property (@(posedge clk)
        rst |=> ({ev_idle, ev_busy, ev_nseq, ev_seq, ev_read, ev_write,
                  ev_size, ev_wait, ev_retry, ev_split} == 15'd0));
endmodule

bind busstat_evgen busstat_evgen_chk u_chk (
    .clk(clk), .rst(rst), .htrans(htrans), .hready(hready), .hwrite(hwrite),
    .hsize(hsize), .hresp(hresp), .filt_en(filt_en), .filt_reject(filt_reject),
    .ev_idle(ev_idle), .ev_busy(ev_busy), .ev_nseq(ev_nseq), .ev_seq(ev_seq),
    .ev_read(ev_read), .ev_write(ev_write), .ev_size(ev_size),
    .ev_wait(ev_wait), .ev_retry(ev_retry), .ev_split(ev_split)
);

// File: tb/tb_busstat_evgen.sv
module tb_busstat_evgen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] htrans = '0;
    logic       hready = 1'b0;
    logic       hwrite = 1'b0;
    logic [2:0] hsize = '0;
    logic [1:0] hresp = '0;
    logic       filt_en = 1'b0;
    logic       filt_reject = 1'b0;
    logic       ev_idle, ev_busy, ev_nseq, ev_seq, ev_read, ev_write;
    logic [5:0] ev_size;
    logic       ev_wait, ev_retry, ev_split;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        logic [14:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    busstat_evgen dut (
        .clk(clk), .rst(rst), .htrans(htrans), .hready(hready), .hwrite(hwrite),
        .hsize(hsize), .hresp(hresp), .filt_en(filt_en), .filt_reject(filt_reject),
        .ev_idle(ev_idle), .ev_busy(ev_busy), .ev_nseq(ev_nseq), .ev_seq(ev_seq),
        .ev_read(ev_read), .ev_write(ev_write), .ev_size(ev_size),
        .ev_wait(ev_wait), .ev_retry(ev_retry), .ev_split(ev_split)
    );

    function automatic logic [14:0] outs();
        return {ev_idle, ev_busy, ev_nseq, ev_seq, ev_read, ev_write,
                ev_size, ev_wait, ev_retry, ev_split};
    endfunction

    // Reference model written from the requirements
    function automatic logic [14:0] model(input logic [1:0] tr, input logic rdy,
                                          input logic wr, input logic [2:0] sz,
                                          input logic [1:0] rs, input logic fe,
                                          input logic fr);
        logic       act;
        logic [5:0] s;
        act = rdy && (tr == 2'd2 || tr == 2'd3);
        for (int n = 0; n < 6; n++) s[n] = act && (sz == n);
        if (fe && fr) return '0;
        return {rdy && tr == 2'd0, rdy && tr == 2'd1, rdy && tr == 2'd2,
                rdy && tr == 2'd3, act && !wr, act && wr, s,
                !rdy && rs == 2'd0, rdy && rs == 2'd2, rdy && rs == 2'd3};
    endfunction

    task automatic drive(input logic [1:0] tr, input logic rdy, input logic wr,
                         input logic [2:0] sz, input logic [1:0] rs,
                         input logic fe, input logic fr, input string tag);
        item_t it;
        @(negedge clk);
        htrans = tr; hready = rdy; hwrite = wr; hsize = sz; hresp = rs;
        filt_en = fe; filt_reject = fr;
        it.exp = model(tr, rdy, wr, sz, rs, fe, fr);
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: results appear after the edge following the drive
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            total++;
            if (outs() !== it.exp) begin
                bad++;
                $display("FAIL %s: got %b expected %b", it.tag, outs(), it.exp);
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #200000;
        bad++;
        $display("FAIL watchdog: got hang expected completion");
        summary();
    end

    initial begin
        // activity during reset; reset must clear outputs (R8)
        htrans = 2'd2; hready = 1'b1; hsize = 3'd2; hresp = 2'd2;
        repeat (3) @(posedge clk);
        #2;
        total++;
        if (outs() !== 15'd0) begin
            bad++;
            $display("FAIL R8 reset: got %b expected %b", outs(), 15'd0);
        end
        @(negedge clk); rst = 1'b0;
        htrans = 2'd0; hready = 1'b0; hresp = 2'd1;

        // R1 transfer types with hready high, and with hready low
        drive(2'd0, 1, 0, 3'd0, 2'd0, 0, 0, "R1");
        drive(2'd1, 1, 0, 3'd0, 2'd0, 0, 0, "R1");
        drive(2'd2, 1, 0, 3'd2, 2'd0, 0, 0, "R1");
        drive(2'd3, 1, 1, 3'd2, 2'd0, 0, 0, "R1");
        drive(2'd3, 0, 1, 3'd2, 2'd1, 0, 0, "R1");
        // R2 direction
        drive(2'd2, 1, 1, 3'd1, 2'd0, 0, 0, "R2");
        drive(2'd3, 1, 0, 3'd1, 2'd0, 0, 0, "R2");
        drive(2'd1, 1, 1, 3'd1, 2'd0, 0, 0, "R2");
        // R3 / R4 every size code, alternating type
        for (int z = 0; z < 8; z++)
            drive((z % 2) ? 2'd3 : 2'd2, 1, z[0], z[2:0], 2'd0, 0, 0,
                  (z < 6) ? "R3" : "R4");
        drive(2'd0, 1, 0, 3'd3, 2'd0, 0, 0, "R4");
        // R5 wait states under any htrans
        drive(2'd2, 0, 0, 3'd2, 2'd0, 0, 0, "R5");
        drive(2'd0, 0, 0, 3'd0, 2'd0, 0, 0, "R5");
        // R6 two-cycle responses and error
        drive(2'd0, 0, 0, 3'd0, 2'd2, 0, 0, "R6");
        drive(2'd0, 1, 0, 3'd0, 2'd2, 0, 0, "R6");
        drive(2'd0, 0, 0, 3'd0, 2'd3, 0, 0, "R6");
        drive(2'd0, 1, 0, 3'd0, 2'd3, 0, 0, "R6");
        drive(2'd0, 1, 0, 3'd0, 2'd1, 0, 0, "R6");
        // coincidence: response completes with a new transfer
        drive(2'd2, 1, 0, 3'd3, 2'd2, 0, 0, "R6");
        drive(2'd3, 1, 1, 3'd5, 2'd3, 0, 0, "R6");
        // R7 gate
        drive(2'd2, 1, 0, 3'd3, 2'd2, 1, 1, "R7");
        drive(2'd0, 0, 0, 3'd0, 2'd0, 1, 1, "R7");
        drive(2'd2, 1, 1, 3'd4, 2'd0, 0, 1, "R7");
        drive(2'd3, 1, 0, 3'd0, 2'd3, 1, 0, "R7");
        // R8 back-to-back pulses then quiet
        drive(2'd2, 1, 0, 3'd0, 2'd0, 0, 0, "R8");
        drive(2'd2, 1, 0, 3'd0, 2'd0, 0, 0, "R8");
        drive(2'd1, 0, 0, 3'd0, 2'd1, 0, 0, "R8");
        drive(2'd1, 0, 0, 3'd0, 2'd1, 0, 0, "R8");
        repeat (3) @(negedge clk);
        summary();
    end
endmodule